// File: doc/BRIEF.md
# Serial Save-Memory Type Detector

This block works out what kind of save memory sits on a serial-peripheral bus. It contains its own byte shifter that drives the clock, chip-select and data lines in SPI mode 0. A single-cycle request starts a fixed two-frame probe. The first frame reads the device status register. The second frame, issued after a short deselect gap, reads three bytes of the identification response. All response bytes are clocked in by transmitting FFh filler bytes. When both frames are finished, the block reports a device class and the number of address bytes that commands to that device use.

The class comes from fixed signatures that combine the status byte with the three ID bytes. An idle or absent bus reads back all ones. A small EEPROM returns a status of F0h and no ID. A 16-bit-address EEPROM or ferroelectric RAM returns a status of 00h and no ID. A flash part returns a status of 00h together with a real ID. Any other combination is reported as unknown. The results are held until the next probe, so the surrounding logic can use them to choose its command formats.

Top module: `bkdet_top`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, and done and busy are low.
- R2: On a probe the block lowers chip select and sends 05h MSB first, then one FFh filler byte, and captures the byte returned during the filler. It uses SPI mode 0: the clock idles low, data is launched on the falling edge and sampled on the rising edge.
- R3: Between the two frames, chip select stays high for at least one serial clock period (2*CLK_DIV system cycles), and the serial clock stays low whenever chip select is high.
- R4: The second frame sends 9Fh followed by three FFh filler bytes and captures the three returned bytes. The first byte received is the most significant.
- R5: Status FFh with ID FF,FF,FF reports class 0 (no device) with 0 address bytes.
- R6: Status F0h with ID FF,FF,FF reports class 1 (9-bit-address EEPROM) with 1 address byte.
- R7: Status 00h with ID FF,FF,FF reports class 2 (16-bit-address EEPROM/FRAM) with 2 address bytes.
- R8: Status 00h with any ID other than FF,FF,FF reports class 3 (flash) with 3 address bytes.
- R9: Every other status/ID combination reports class 4 (unknown) with 0 address bytes.
- R10: Each probe produces exactly one single-cycle done pulse. Class and address-byte outputs are valid in that cycle and hold until the next probe. Busy is high from the accepted probe until done.
- R11: A probe request that arrives while a probe is running is ignored: no extra frame and no extra done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| probe_i | input | 1 | Single-cycle request to start detection |
| busy_o | output | 1 | Detection in progress |
| done_o | output | 1 | One-cycle pulse when the result is ready |
| class_o | output | 3 | Device class: 0 none, 1 EEPROM 9-bit, 2 EEPROM/FRAM 16-bit, 3 flash, 4 unknown |
| addr_bytes_o | output | 2 | Address bytes used by the detected device |
| spi_sclk_o | output | 1 | Serial clock, idles low |
| spi_cs_n_o | output | 1 | Active-low chip select |
| spi_mosi_o | output | 1 | Serial data to the device |
| spi_miso_i | input | 1 | Serial data from the device |

## Verification
Several properties are checked on every cycle by assertions. The clock stays low while the device is deselected, and a byte transfer starts only while chip select is low and the shifter is free. The deselect gap between frames is at least one serial clock period. A new frame opens only from the idle or gap state, and done never lasts longer than one cycle. Other behaviour can only be shown by the bench's scenarios, which run against a serial device model. These cover the exact opcode and filler bytes on the wire, the bit order of the captured responses, the class and address-byte result for each signature, unknown combinations, held results, and requests that are ignored during a probe.

// File: rtl/bkdet_pkg.sv
package bkdet_pkg;

    typedef enum logic [2:0] {
        DEV_NONE    = 3'd0,
        DEV_EE9     = 3'd1,
        DEV_EE16    = 3'd2,
        DEV_FLASH   = 3'd3,
        DEV_UNKNOWN = 3'd4
    } dev_class_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_ISSUE,
        SQ_WAIT,
        SQ_GAP,
        SQ_REPORT
    } seq_state_e;

    localparam logic [7:0] OP_STATUS = 8'h05;
    localparam logic [7:0] OP_IDENT  = 8'h9F;
    localparam logic [7:0] FILLER    = 8'hFF;
    localparam int         ID_LEN    = 3;

endpackage

// File: rtl/bkdet_shifter.sv
module bkdet_shifter #(
    parameter int CLK_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] tx_i,
    output logic       busy_o,
    output logic       done_o,
    output logic [7:0] rx_o,
    output logic       sclk_o,
    output logic       mosi_o,
    input  logic       miso_i
);
    localparam int CW = $clog2(CLK_DIV) + 1;

    typedef struct packed {
        logic          busy;
        logic          sclk;
        logic [CW-1:0] cnt;
        logic [2:0]    bits;
        logic [7:0]    tx;
        logic [7:0]    rx;
        logic          done;
    } shf_t;

    shf_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.busy) begin
            if (start_i) begin
                d.busy = 1'b1;
                d.tx   = tx_i;
                d.cnt  = '0;
                d.bits = '0;
                d.sclk = 1'b0;
            end
        end else if (q.cnt == CW'(CLK_DIV - 1)) begin
            d.cnt = '0;
            if (!q.sclk) begin
                d.sclk = 1'b1;
                d.rx   = {q.rx[6:0], miso_i};
            end else begin
                d.sclk = 1'b0;
                d.tx   = {q.tx[6:0], 1'b1};
                d.bits = q.bits + 3'd1;
                if (q.bits == 3'd7) begin
                    d.busy = 1'b0;
                    d.done = 1'b1;
                end
            end
        end else begin
            d.cnt = q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{busy: 1'b0, sclk: 1'b0, cnt: '0, bits: '0,
                           tx: 8'hFF, rx: '0, done: 1'b0};
        else        q <= d;
    end

    assign busy_o = q.busy;
    assign done_o = q.done;
    assign rx_o   = q.rx;
    assign sclk_o = q.sclk;
    assign mosi_o = q.tx[7];

    assert_idle_clock_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !sclk_o);

endmodule

// File: rtl/bkdet_classify.sv
module bkdet_classify
    import bkdet_pkg::*;
(
    input  logic [7:0]          status_i,
    input  logic [8*ID_LEN-1:0] id_i,
    output logic [2:0]          class_o,
    output logic [1:0]          abytes_o
);
    logic id_blank;

    always_comb begin
        id_blank = &id_i;
        class_o  = DEV_UNKNOWN;
        abytes_o = 2'd0;
        if (id_blank) begin
            case (status_i)
                8'hFF: begin class_o = DEV_NONE; abytes_o = 2'd0; end
                8'hF0: begin class_o = DEV_EE9;  abytes_o = 2'd1; end
                8'h00: begin class_o = DEV_EE16; abytes_o = 2'd2; end
                default: begin class_o = DEV_UNKNOWN; abytes_o = 2'd0; end
            endcase
        end else if (status_i == 8'h00) begin
            class_o  = DEV_FLASH;
            abytes_o = 2'd3;
        end
    end

endmodule

// File: rtl/bkdet_seq.sv
module bkdet_seq
    import bkdet_pkg::*;
#(
    parameter int CLK_DIV = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                probe_i,
    output logic                byte_start_o,
    output logic [7:0]          byte_tx_o,
    input  logic                byte_done_i,
    input  logic [7:0]          byte_rx_i,
    output logic                cs_n_o,
    output logic [7:0]          status_o,
    output logic [8*ID_LEN-1:0] id_o,
    input  logic [2:0]          cls_i,
    input  logic [1:0]          ab_i,
    output logic                busy_o,
    output logic                done_o,
    output logic [2:0]          class_o,
    output logic [1:0]          abytes_o
);
    localparam int GAP = 2 * CLK_DIV;
    localparam int GW  = $clog2(GAP) + 1;
    localparam int IW  = $clog2(ID_LEN + 1);

    typedef struct packed {
        seq_state_e          st;
        logic                cs_n;
        logic                frame;
        logic [IW-1:0]       idx;
        logic [GW-1:0]       gcnt;
        logic [7:0]          status;
        logic [8*ID_LEN-1:0] id;
        logic                start;
        logic [7:0]          tx;
        logic                done;
        logic [2:0]          cls;
        logic [1:0]          ab;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d       = q;
        d.start = 1'b0;
        d.done  = 1'b0;
        case (q.st)
            SQ_IDLE: if (probe_i) begin
                d.cs_n  = 1'b0;
                d.frame = 1'b0;
                d.idx   = '0;
                d.st    = SQ_ISSUE;
            end
            SQ_ISSUE: begin
                d.start = 1'b1;
                d.tx    = (q.idx == '0) ? (q.frame ? OP_IDENT : OP_STATUS) : FILLER;
                d.st    = SQ_WAIT;
            end
            SQ_WAIT: if (byte_done_i) begin
                if (q.idx != '0) begin
                    if (!q.frame) d.status = byte_rx_i;
                    else          d.id     = {q.id[8*ID_LEN-9:0], byte_rx_i};
                end
                if ((!q.frame && q.idx == IW'(1)) || (q.frame && q.idx == IW'(ID_LEN))) begin
                    d.cs_n = 1'b1;
                    if (!q.frame) begin
                        d.st   = SQ_GAP;
                        d.gcnt = '0;
                    end else begin
                        d.st = SQ_REPORT;
                    end
                end else begin
                    d.idx = q.idx + IW'(1);
                    d.st  = SQ_ISSUE;
                end
            end
            SQ_GAP: begin
                d.gcnt = q.gcnt + GW'(1);
                if (q.gcnt == GW'(GAP - 1)) begin
                    d.cs_n  = 1'b0;
                    d.frame = 1'b1;
                    d.idx   = '0;
                    d.st    = SQ_ISSUE;
                end
            end
            SQ_REPORT: begin
                d.done = 1'b1;
                d.cls  = cls_i;
                d.ab   = ab_i;
                d.st   = SQ_IDLE;
            end
            default: d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: SQ_IDLE, cs_n: 1'b1, frame: 1'b0, idx: '0, gcnt: '0,
                           status: '0, id: '0, start: 1'b0, tx: FILLER, done: 1'b0,
                           cls: DEV_NONE, ab: 2'd0};
        else        q <= d;
    end

    assign byte_start_o = q.start;
    assign byte_tx_o    = q.tx;
    assign cs_n_o       = q.cs_n;
    assign status_o     = q.status;
    assign id_o         = q.id;
    assign busy_o       = (q.st != SQ_IDLE);
    assign done_o       = q.done;
    assign class_o      = q.cls;
    assign abytes_o     = q.ab;

    // Independent watch of the deselect run length
    logic [GW-1:0] chk_hi;
    logic          chk_seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_hi   <= '0;
            chk_seen <= 1'b0;
        end else if (cs_n_o) begin
            if (chk_hi < GW'(GAP)) chk_hi <= chk_hi + GW'(1);
        end else begin
            chk_hi   <= '0;
            chk_seen <= 1'b1;
        end
    end

    assert_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cs_n_o) && chk_seen) |-> (chk_hi >= GW'(GAP)));

    assert_frame_from_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> ($past(q.st) == SQ_IDLE || $past(q.st) == SQ_GAP));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: rtl/bkdet_top.sv
module bkdet_top #(
    parameter int CLK_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       probe_i,
    output logic       busy_o,
    output logic       done_o,
    output logic [2:0] class_o,
    output logic [1:0] addr_bytes_o,
    output logic       spi_sclk_o,
    output logic       spi_cs_n_o,
    output logic       spi_mosi_o,
    input  logic       spi_miso_i
);
    import bkdet_pkg::*;

    logic                byte_start, byte_done, shf_busy;
    logic [7:0]          byte_tx, byte_rx, status;
    logic [8*ID_LEN-1:0] id;
    logic [2:0]          cls;
    logic [1:0]          ab;

    bkdet_shifter #(.CLK_DIV(CLK_DIV)) u_shf (
        .clk(clk), .rst_n(rst_n), .start_i(byte_start), .tx_i(byte_tx),
        .busy_o(shf_busy), .done_o(byte_done), .rx_o(byte_rx),
        .sclk_o(spi_sclk_o), .mosi_o(spi_mosi_o), .miso_i(spi_miso_i)
    );

    bkdet_classify u_cls (
        .status_i(status), .id_i(id), .class_o(cls), .abytes_o(ab)
    );

    bkdet_seq #(.CLK_DIV(CLK_DIV)) u_seq (
        .clk(clk), .rst_n(rst_n), .probe_i(probe_i),
        .byte_start_o(byte_start), .byte_tx_o(byte_tx),
        .byte_done_i(byte_done), .byte_rx_i(byte_rx),
        .cs_n_o(spi_cs_n_o), .status_o(status), .id_o(id),
        .cls_i(cls), .ab_i(ab),
        .busy_o(busy_o), .done_o(done_o),
        .class_o(class_o), .abytes_o(addr_bytes_o)
    );

    assert_sclk_low_deselected_R3: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n_o |-> !spi_sclk_o);

    assert_start_selected_R2: assert property (@(posedge clk) disable iff (!rst_n)
        byte_start |-> (!spi_cs_n_o && !shf_busy));

endmodule

// File: tb/tb_bkdet_top.sv
`timescale 1ns/1ps
module tb_bkdet_top;
    localparam int DIV = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       probe = 1'b0;
    logic       busy, done, sclk, cs_n, mosi;
    logic       miso = 1'b1;
    logic [2:0] cls;
    logic [1:0] ab;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    bkdet_top #(.CLK_DIV(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .probe_i(probe), .busy_o(busy), .done_o(done),
        .class_o(cls), .addr_bytes_o(ab), .spi_sclk_o(sclk), .spi_cs_n_o(cs_n),
        .spi_mosi_o(mosi), .spi_miso_i(miso)
    );

    // Serial device model
    bit          dev_present = 0;
    logic [7:0]  dev_status = 8'hFF;
    logic [23:0] dev_id = 24'hFFFFFF;
    int          fr = -1;
    int          bitcnt = 0;
    logic [7:0]  sh = 8'h00;
    logic [7:0]  rec [4][8];
    int          nb [4];

    always @(negedge cs_n) begin
        fr = fr + 1;
        bitcnt = 0;
    end
    always @(posedge cs_n) miso = 1'b1;

    always @(posedge sclk) if (!cs_n) begin
        sh = {sh[6:0], mosi};
        bitcnt = bitcnt + 1;
        if (bitcnt % 8 == 0 && fr >= 0 && fr < 4 && bitcnt / 8 <= 8) begin
            rec[fr][bitcnt/8-1] = sh;
            nb[fr] = bitcnt / 8;
        end
    end

    always @(negedge sclk) if (!cs_n && bitcnt >= 8 && fr >= 0 && fr < 4) begin
        int b;
        int k;
        b = bitcnt - 8;
        k = b / 8;
        if (!dev_present) miso = 1'b1;
        else if (rec[fr][0] == 8'h05) miso = dev_status[7 - (b % 8)];
        else if (rec[fr][0] == 8'h9F) miso = (k < 3) ? dev_id[23 - 8*k - (b % 8)] : 1'b1;
        else miso = 1'b1;
    end

    // Deselect-gap and done monitors
    int  hi_run = 0;
    int  gap_last = 0;
    bit  prev_cs = 1;
    int  done_cnt = 0;
    int  sclk_hi_desel = 0;
    always @(posedge clk) begin
        if (cs_n) hi_run = hi_run + 1;
        else begin
            if (prev_cs) gap_last = hi_run;
            hi_run = 0;
        end
        prev_cs = cs_n;
        if (done) done_cnt = done_cnt + 1;
        if (rst_n && cs_n && sclk) sclk_hi_desel = sclk_hi_desel + 1;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_log();
        fr = -1;
        for (int i = 0; i < 4; i++) nb[i] = 0;
        done_cnt = 0;
        gap_last = 0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic check_frames();
        check(fr == 1, "R4 frame count", fr + 1, 2);
        check(nb[0] == 2 && rec[0][0] == 8'h05 && rec[0][1] == 8'hFF, "R2 status frame",
              {nb[0], rec[0][0], rec[0][1]}, {32'd2, 8'h05, 8'hFF});
        check(nb[1] == 4 && rec[1][0] == 8'h9F && rec[1][1] == 8'hFF &&
              rec[1][2] == 8'hFF && rec[1][3] == 8'hFF, "R4 ident frame",
              {rec[1][0], rec[1][1], rec[1][2], rec[1][3]}, 32'h9FFFFFFF);
        check(gap_last >= 2*DIV, "R3 deselect gap", gap_last, 2*DIV);
    endtask

    task automatic run_probe(input bit pres, input logic [7:0] st, input logic [23:0] id,
                             input logic [2:0] ecls, input logic [1:0] eab, input string tag);
        dev_present = pres;
        dev_status = st;
        dev_id = id;
        clear_log();
        @(negedge clk) probe = 1'b1;
        @(negedge clk) probe = 1'b0;
        check(busy == 1'b1, "R10 busy", busy, 1);
        wait_done();
        check(done == 1'b1, "R10 done", done, 1);
        check(cls == ecls, {tag, " class"}, cls, ecls);
        check(ab == eab, {tag, " addr bytes"}, ab, eab);
        check_frames();
        repeat (12) @(negedge clk);
        check(done == 1'b0 && cls == ecls && ab == eab, "R10 hold", {done, cls, ab}, {1'b0, ecls, eab});
        check(done_cnt == 1 && busy == 1'b0, "R10 one pulse", done_cnt, 1);
    endtask

    task automatic test_reset();
        check(cs_n == 1'b1, "R1 cs", cs_n, 1);
        check(sclk == 1'b0, "R1 sclk", sclk, 0);
        check(done == 1'b0, "R1 done", done, 0);
        check(busy == 1'b0, "R1 busy", busy, 0);
    endtask

    task automatic test_ignore_R11();
        dev_present = 1;
        dev_status = 8'h00;
        dev_id = 24'hFFFFFF;
        clear_log();
        @(negedge clk) probe = 1'b1;
        @(negedge clk) probe = 1'b0;
        repeat (30) @(negedge clk);
        probe = 1'b1;
        @(negedge clk) probe = 1'b0;
        repeat (90) @(negedge clk);
        probe = 1'b1;
        repeat (3) @(negedge clk);
        probe = 1'b0;
        wait_done();
        check(cls == 3'd2 && ab == 2'd2, "R11 result", {cls, ab}, {3'd2, 2'd2});
        repeat (300) @(negedge clk);
        check(done_cnt == 1, "R11 single done", done_cnt, 1);
        check(fr == 1, "R11 no extra frame", fr + 1, 2);
        check(busy == 1'b0, "R11 idle after", busy, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        run_probe(1'b0, 8'hFF, 24'hFFFFFF, 3'd0, 2'd0, "R5");
        run_probe(1'b1, 8'hF0, 24'hFFFFFF, 3'd1, 2'd1, "R6");
        run_probe(1'b1, 8'h00, 24'hFFFFFF, 3'd2, 2'd2, "R7");
        run_probe(1'b1, 8'h00, 24'hC22013, 3'd3, 2'd3, "R8");
        run_probe(1'b1, 8'h00, 24'hFFFF7F, 3'd3, 2'd3, "R8 last bit");
        run_probe(1'b1, 8'h02, 24'hFFFFFF, 3'd4, 2'd0, "R9 status");
        run_probe(1'b1, 8'hF0, 24'h20FFFF, 3'd4, 2'd0, "R9 ident");
        test_ignore_R11();
        check(sclk_hi_desel == 0, "R3 clock while deselected", sclk_hi_desel, 0);
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule